// File: doc/BRIEF.md
# Parallel-In Word FIFO with Occupancy Flags

This block is a single-clock word buffer that sits between a parallel producer and a serial output stage. The producer presents a 9-bit word with a write enable, and the serial stage asks for the next complete word with a read request. The accepted word is loaded into an output register that the shifter then consumes. Storage depth is a power-of-two parameter.

Four active-low status flags are decoded from a registered occupancy count: full, empty, more-than-half, and a shared edge flag. The edge flag warns when the buffer is in either its bottom or its top eighth of capacity. A rewind command sends the read side back to storage location zero and leaves the write side where it is. The words written since reset can then be replayed in their original order.

Top module: `par_fifo`

## Requirements
- R1: While reset is low and after it is released, full_n=1, half_n=1, empty_n=0, edge_n=0 and rd_data=0. The first word written after reset is the first word read back.
- R2: A write is accepted on a clock edge when wr_en=1, occupancy is below DEPTH and rewind=0. Accepted words are read back in the order they were written.
- R3: A write with occupancy equal to DEPTH stores nothing and does not advance the write position. This holds even when a read is accepted in the same cycle.
- R4: A read is accepted on a clock edge when rd_req=1, occupancy is non-zero and rewind=0. On that edge rd_data takes the oldest stored word.
- R5: A read at zero occupancy leaves rd_data unchanged. A write in that same cycle is still accepted.
- R6: An accepted read and an accepted write in the same cycle leave the occupancy, and so all flags, unchanged.
- R7: full_n is low exactly when occupancy equals DEPTH. empty_n is low exactly when occupancy is zero. Flags follow the edge that changed occupancy, with no extra latency.
- R8: half_n is low exactly when occupancy is greater than DEPTH/2. At DEPTH/2 it is still high.
- R9: edge_n is low exactly when occupancy is below DEPTH/8 or above DEPTH-DEPTH/8.
- R10: With rewind=1 the read position returns to location zero and the write position is kept. Occupancy becomes the number of words written since reset, provided that number is at most DEPTH. Any write or read requested in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable, sampled on the clock edge |
| wr_data | input | DATA_W | Parallel word to store |
| rd_req | input | 1 | Request for the next word from the serial stage |
| rewind | input | 1 | Return the read position to location zero |
| rd_data | output | DATA_W | Output register holding the last word read |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| empty_n | output | 1 | Low when the buffer holds no word |
| half_n | output | 1 | Low when more than half the depth is used |
| edge_n | output | 1 | Low in the bottom or top eighth of occupancy |

## Verification
A write and a read can land on the same edge. The cases that matter are the two boundaries where only one of them may be honoured.

At zero occupancy the bench requests both in one cycle. It then confirms that rd_data keeps its old word, that the flags move to one stored word, and that the written word is the next one returned. At full depth the bench again requests both. It expects the oldest word on rd_data and the flags of DEPTH-1 words, and it expects the rejected word never to appear during the following drain.

A rewind issued together with a write is judged the same way. The write must be absent from the replayed sequence.

// File: rtl/par_fifo_pkg.sv
package par_fifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BOTH = 2'd3
    } op_e;

    typedef struct packed {
        logic full_n;
        logic empty_n;
        logic half_n;
        logic edge_n;
    } flag_t;

endpackage

// File: rtl/pf_ptr_ctrl.sv
module pf_ptr_ctrl
    import par_fifo_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_req,
    input  logic              rewind,
    output logic              push,
    output logic              pop,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0]  wr_ptr;
        logic [ADDR_W-1:0] rd_ptr;
        logic [CNT_W-1:0]  count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    op_e        op;
    logic       push_ok, pop_ok;

    always_comb begin
        push_ok = wr_en  && (st_q.count != CNT_FULL) && !rewind;
        pop_ok  = rd_req && (st_q.count != '0)       && !rewind;
        op      = op_e'({pop_ok, push_ok});
        st_d    = st_q;
        if (rewind) begin
            st_d.rd_ptr = '0;
            st_d.count  = (st_q.wr_ptr > CNT_FULL) ? CNT_FULL : st_q.wr_ptr;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    st_d.wr_ptr = st_q.wr_ptr + 1'b1;
                    st_d.count  = st_q.count + 1'b1;
                end
                OP_POP: begin
                    st_d.rd_ptr = st_q.rd_ptr + 1'b1;
                    st_d.count  = st_q.count - 1'b1;
                end
                OP_BOTH: begin
                    st_d.wr_ptr = st_q.wr_ptr + 1'b1;
                    st_d.rd_ptr = st_q.rd_ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push    = push_ok;
    assign pop     = pop_ok;
    assign wr_addr = st_q.wr_ptr[ADDR_W-1:0];
    assign rd_addr = st_q.rd_ptr;
    assign count   = st_q.count;

endmodule

// File: rtl/pf_store.sv
module pf_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = re ? mem[raddr] : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pf_flag_gen.sv
module pf_flag_gen
    import par_fifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] count,
    output flag_t            flags
);

    localparam logic [CNT_W-1:0] TH_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TH_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] TH_LOW  = CNT_W'(DEPTH / 8);
    localparam logic [CNT_W-1:0] TH_HIGH = CNT_W'(DEPTH - DEPTH / 8);

    always_comb begin
        flags.full_n  = (count != TH_FULL);
        flags.empty_n = (count != '0);
        flags.half_n  = !(count > TH_HALF);
        flags.edge_n  = !((count < TH_LOW) || (count > TH_HIGH));
    end

endmodule

// File: rtl/par_fifo.sv
module par_fifo
    import par_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_n,
    output logic              empty_n,
    output logic              half_n,
    output logic              edge_n
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic              push, pop;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0]  count;
    flag_t             flags;

    pf_ptr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_req  (rd_req),
        .rewind  (rewind),
        .push    (push),
        .pop     (pop),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .count   (count)
    );

    pf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (pop),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    pf_flag_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
        .count (count),
        .flags (flags)
    );

    assign full_n  = flags.full_n;
    assign empty_n = flags.empty_n;
    assign half_n  = flags.half_n;
    assign edge_n  = flags.edge_n;

endmodule

// File: rtl/par_fifo_chk.sv
module par_fifo_chk #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_req,
    input logic              rewind,
    input logic [DATA_W-1:0] rd_data,
    input logic              full_n,
    input logic              empty_n,
    input logic              half_n,
    input logic              edge_n
);

    AST_RESET_FLAGS: assert property (@(posedge clk) !rst_n |=> (full_n && !empty_n && half_n && !edge_n && rd_data == '0)); // R1
    AST_FULL_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (!full_n && wr_en && !rd_req && !rewind) |=> (!full_n && $stable(rd_data))); // R3
    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!empty_n && rd_req && !rewind) |=> $stable(rd_data)); // R5
    AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && rd_req && empty_n && full_n && !rewind) |=> $stable({full_n, empty_n, half_n, edge_n})); // R6
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (full_n || empty_n)); // R7
    AST_FULL_UPPER: assert property (@(posedge clk) disable iff (!rst_n) !full_n |-> (!half_n && !edge_n)); // R8
    AST_EMPTY_LOWER: assert property (@(posedge clk) disable iff (!rst_n) !empty_n |-> (half_n && !edge_n)); // R9

endmodule

bind par_fifo par_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_req  (rd_req),
    .rewind  (rewind),
    .rd_data (rd_data),
    .full_n  (full_n),
    .empty_n (empty_n),
    .half_n  (half_n),
    .edge_n  (edge_n)
);

// File: tb/par_fifo_test.sv
module par_fifo_test;

    localparam int DW = 9;
    localparam int DP = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_req = 1'b0;
    logic          rewind = 1'b0;
    logic [DW-1:0] rd_data;
    logic          full_n, empty_n, half_n, edge_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    par_fifo #(.DATA_W(DW), .DEPTH(DP)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_req(rd_req), .rewind(rewind), .rd_data(rd_data),
        .full_n(full_n), .empty_n(empty_n), .half_n(half_n), .edge_n(edge_n)
    );

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic          rw;
        logic [DW-1:0] din;
        logic [3:0]    fl;
        logic          dchk;
        logic [DW-1:0] dexp;
    } vec_t;

    // flags order: {full_n, empty_n, half_n, edge_n}
    localparam vec_t VT [8] = '{
        '{1'b1, 1'b0, 1'b0, 9'h101, 4'b1110, 1'b0, 9'h000},  // R2
        '{1'b1, 1'b0, 1'b0, 9'h0A5, 4'b1110, 1'b0, 9'h000},  // R2
        '{1'b0, 1'b1, 1'b0, 9'h000, 4'b1110, 1'b1, 9'h101},  // R4
        '{1'b1, 1'b1, 1'b0, 9'h033, 4'b1110, 1'b1, 9'h0A5},  // R6
        '{1'b0, 1'b1, 1'b0, 9'h000, 4'b1010, 1'b1, 9'h033},  // R4
        '{1'b0, 1'b1, 1'b0, 9'h000, 4'b1010, 1'b1, 9'h033},  // R5
        '{1'b1, 1'b1, 1'b0, 9'h1FF, 4'b1110, 1'b1, 9'h033},  // R5
        '{1'b0, 1'b1, 1'b0, 9'h000, 4'b1010, 1'b1, 9'h1FF}   // R4
    };

    function automatic logic [3:0] exp_flags(int c);
        return {c != DP, c != 0, !(c > DP / 2), !((c < DP / 8) || (c > DP - DP / 8))};
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fl_now();
        return DW'({full_n, empty_n, half_n, edge_n});
    endfunction

    // called at a negedge; returns at the next negedge, after one posedge
    task automatic step(logic w, logic r, logic rw, logic [DW-1:0] d);
        wr_en = w; rd_req = r; rewind = rw; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_req = 1'b0; rewind = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 flags in reset", fl_now(), 9'b1010);
        check("R1 rd_data in reset", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", fl_now(), 9'b1010);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // vector table
        for (int i = 0; i < 8; i++) begin
            step(VT[i].wr, VT[i].rd, VT[i].rw, VT[i].din);
            check($sformatf("R7 R8 R9 vector %0d flags", i), fl_now(), DW'(VT[i].fl));
            if (VT[i].dchk)
                check($sformatf("R4 R5 R6 vector %0d data", i), rd_data, VT[i].dexp);
        end

        // fill through every threshold
        do_reset();
        for (int c = 1; c <= DP; c++) begin
            step(1'b1, 1'b0, 1'b0, DW'(c - 1));
            check($sformatf("R7 R8 R9 R2 flags at %0d", c), fl_now(), DW'(exp_flags(c)));
        end
        step(1'b1, 1'b0, 1'b0, 9'h1AA);
        check("R3 write at full, flags", fl_now(), DW'(exp_flags(DP)));
        step(1'b1, 1'b1, 1'b0, 9'h1AA);
        check("R3 write+read at full, data", rd_data, 9'h000);
        check("R3 write+read at full, flags", fl_now(), DW'(exp_flags(DP - 1)));
        for (int i = 1; i < DP; i++) begin
            step(1'b0, 1'b1, 1'b0, '0);
            check($sformatf("R2 R3 drain word %0d", i), rd_data, DW'(i));
            check($sformatf("R7 R8 R9 drain flags %0d", i), fl_now(), DW'(exp_flags(DP - 1 - i)));
        end
        step(1'b0, 1'b1, 1'b0, '0);
        check("R5 read when empty", rd_data, DW'(DP - 1));

        // rewind
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, DW'(100 + i));
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, 1'b0, '0);
            check("R4 pre-rewind read", rd_data, DW'(100 + i));
        end
        check("R9 flags at 6", fl_now(), DW'(exp_flags(6)));
        wr_en = 1'b1; rd_req = 1'b1; wr_data = 9'h155;
        step(1'b1, 1'b1, 1'b1, 9'h155);
        check("R10 rewind flags", fl_now(), DW'(exp_flags(10)));
        check("R10 rewind ignores read", rd_data, DW'(103));
        step(1'b1, 1'b0, 1'b0, 9'h077);
        check("R10 flags after post-rewind write", fl_now(), DW'(exp_flags(11)));
        for (int i = 0; i < 10; i++) begin
            step(1'b0, 1'b1, 1'b0, '0);
            check($sformatf("R10 replay word %0d", i), rd_data, DW'(100 + i));
        end
        step(1'b0, 1'b1, 1'b0, '0);
        check("R10 write position kept", rd_data, 9'h077);
        check("R7 empty after replay", fl_now(), 9'b1010);

        // reset in mid-operation
        step(1'b1, 1'b0, 1'b0, 9'h0F0);
        do_reset();
        step(1'b1, 1'b0, 1'b0, 9'h00C);
        step(1'b0, 1'b1, 1'b0, '0);
        check("R1 first word after reset", rd_data, 9'h00C);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule